// File: doc/BRIEF.md
# Two-Stage Loop Compensation Filter

This block is the digital compensator that sits between a differential loop ADC and a pulse-width generator in a switching regulator. It takes one signed 6-bit error sample per `err_valid_i` strobe and returns a 9-bit duty command. The first stage is a PID section: an integrator provides the pole, and the proportional and derivative terms provide the two zeros. The second stage is chosen by software. It is either a cascade of two first-order low-pass sections, or a boxcar (SINC) decimator whose ratio is a power of two. The datapath is 22 bits wide and saturates. The duty command is clamped to 0..511.

Software loads six parameters through a small write-only register bank: three PID gains, the low-pass shift, the decimation exponent and the output scaling shift. Writes go to a shadow set. The shadow set is copied into the working set only when a sample is accepted, so every output comes from one coherent set of parameters. When dither is enabled, an LFSR adds broadband noise below the output LSB. This moves the duty command by up to one code and raises the time-averaged resolution by up to 6 bits.

Top module: `loop_comp_filter`

## Requirements
- R1: For each accepted error sample e, the integrator updates as I = sat(I + ki*e). The PID value is p = sat(kp*e + I + kd*(e - e_prev)). Here I is the updated integrator and e_prev is the previous accepted sample, which is 0 after reset.
- R2: The integrator and the PID sum saturate at -2097152 and +2097151. They never wrap, so the integrator moves by at most |ki*e| per sample.
- R3: With `sinc_sel_i`=0 the second stage applies, in order, a = a + ((p - a) >>> k) and b = b + ((a_new - b) >>> k), using floor shifts. The output is b_new, and one output is produced for every sample.
- R4: With `sinc_sel_i`=1 the stage adds p into a running sum. When its sample counter is at least N-1, where N = 2^d, it outputs (sum including p) >>> d and clears both the sum and the counter. Otherwise it only accumulates and produces no output. A d above 4 is treated as 4. Lowering d therefore ends the current block early. Both second stages update on every sample, whichever one is selected.
- R5: The duty value is the second-stage result x, plus any dither, arithmetically shifted right by s and clamped to 0..511. A shift s below 6 is treated as 6.
- R6: The dither source is an 8-bit LFSR that resets to 0x01. Its next value is {l[6:0], l[7]^l[5]^l[4]^l[3]}. The value added to x is l[5:0] << (s-6). The LFSR advances once for each output produced while dither is enabled, and does not change otherwise.
- R7: The register map is: address 0 = kp, 1 = ki, 2 = kd (each signed 8-bit); 3 = k (bits 2:0); 4 = d (bits 2:0); 5 = s (bits 3:0). Addresses 6 and 7 are ignored. A write affects only samples accepted at later edges. A sample accepted at the same edge as a write uses the earlier values. `sinc_sel_i` and `dither_en_i` are sampled together with each sample.
- R8: A sample accepted at edge n produces a `duty_valid_o` pulse in the cycle after edge n+1, if that sample produces an output. `duty_valid_o` is never high otherwise. `duty_o` changes only together with `duty_valid_o`.
- R9: Reset clears the duty output, `duty_valid_o`, all parameters and all filter state to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Error sample strobe |
| err_i | input | 6 | Signed error sample |
| coef_we_i | input | 1 | Parameter write enable |
| coef_addr_i | input | 3 | Parameter address |
| coef_data_i | input | 8 | Parameter write data |
| sinc_sel_i | input | 1 | Second stage: 0 low-pass, 1 SINC decimator |
| dither_en_i | input | 1 | Dither enable |
| duty_valid_o | output | 1 | Duty command strobe |
| duty_o | output | 9 | Duty command |

## Verification
The PID path is driven with short signed steps that isolate the proportional, derivative and integral terms. Long runs of full-scale error of each sign then separate saturation from wraparound and check both clamp limits. Low-pass runs with several shifts show the two-pole settling shape. SINC runs with d=2, with an oversized d, and with d lowered in the middle of a block confirm the output spacing, the block average and the early end of a block. Dither runs at two scaling shifts, a write issued on the same edge as a sample, writes to unused addresses, and a long random mix of modes and mid-run parameter writes cover the LFSR sequence, the boundary at which writes take effect, and the interaction between the two second stages.

// File: rtl/lcf_pkg.sv
package lcf_pkg;
  localparam int REG_KP  = 0;
  localparam int REG_KI  = 1;
  localparam int REG_KD  = 2;
  localparam int REG_LSH = 3;
  localparam int REG_DEC = 4;
  localparam int REG_OSH = 5;

  typedef enum logic {STG_LPF = 1'b0, STG_SINC = 1'b1} stage_e;
endpackage

// File: rtl/lcf_pid.sv
module lcf_pid #(
  parameter int ERR_W  = 6,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 22
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [ERR_W-1:0]  e_i,
  input  logic signed [COEF_W-1:0] kp_i,
  input  logic signed [COEF_W-1:0] ki_i,
  input  logic signed [COEF_W-1:0] kd_i,
  output logic signed [ACC_W-1:0]  pid_o,
  output logic signed [ACC_W-1:0]  acc_o
);
  localparam int PROD_W = ERR_W + 1 + COEF_W;
  localparam int SUM_W  = ACC_W + 2;
  localparam logic signed [SUM_W-1:0] HI = {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LO = {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

  function automatic logic signed [ACC_W-1:0] sat(input logic signed [SUM_W-1:0] v);
    if (v > HI)      return HI[ACC_W-1:0];
    else if (v < LO) return LO[ACC_W-1:0];
    else             return v[ACC_W-1:0];
  endfunction

  logic signed [ACC_W-1:0]  acc_q, acc_nxt;
  logic signed [ERR_W-1:0]  e_prev_q;
  logic signed [ERR_W:0]    diff;
  logic signed [PROD_W-1:0] p_term, i_term, d_term;

  always_comb begin
    diff    = ERR_W'(e_i) - ERR_W'(e_prev_q);
    diff    = (ERR_W+1)'(e_i) - (ERR_W+1)'(e_prev_q);
    p_term  = PROD_W'(e_i) * PROD_W'(kp_i);
    i_term  = PROD_W'(e_i) * PROD_W'(ki_i);
    d_term  = PROD_W'(diff) * PROD_W'(kd_i);
    acc_nxt = sat(SUM_W'(acc_q) + SUM_W'(i_term));
    pid_o   = sat(SUM_W'(acc_nxt) + SUM_W'(p_term) + SUM_W'(d_term));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      e_prev_q <= '0;
    end else if (en_i) begin
      acc_q    <= acc_nxt;
      e_prev_q <= e_i;
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/lcf_lpf.sv
module lcf_lpf #(
  parameter int ACC_W = 22,
  parameter int SH_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] x_i,
  input  logic [SH_W-1:0]         sh_i,
  output logic signed [ACC_W-1:0] y_o
);
  logic signed [ACC_W-1:0] s1_q, s2_q, s1_n, s2_n;
  logic signed [ACC_W:0]   d1, d2, t1, t2;

  always_comb begin
    d1   = (ACC_W+1)'(x_i) - (ACC_W+1)'(s1_q);
    t1   = (ACC_W+1)'(s1_q) + (d1 >>> sh_i);
    s1_n = t1[ACC_W-1:0];
    d2   = (ACC_W+1)'(s1_n) - (ACC_W+1)'(s2_q);
    t2   = (ACC_W+1)'(s2_q) + (d2 >>> sh_i);
    s2_n = t2[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else if (en_i) begin
      s1_q <= s1_n;
      s2_q <= s2_n;
    end
  end

  assign y_o = s2_n;
endmodule

// File: rtl/lcf_sinc.sv
module lcf_sinc #(
  parameter int ACC_W  = 22,
  parameter int L2_W   = 3,
  parameter int MAX_L2 = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [ACC_W-1:0] x_i,
  input  logic [L2_W-1:0]         l2_i,
  output logic signed [ACC_W-1:0] y_o,
  output logic                    fire_o
);
  localparam int SW = ACC_W + MAX_L2;

  logic signed [SW-1:0] sum_q, sum_n;
  logic [MAX_L2-1:0]    cnt_q, lim;
  logic [L2_W-1:0]      eff_l2;

  always_comb begin
    eff_l2 = (l2_i > L2_W'(MAX_L2)) ? L2_W'(MAX_L2) : l2_i;
    lim    = MAX_L2'((1 << eff_l2) - 1);
    fire_o = (cnt_q >= lim);
    sum_n  = sum_q + SW'(x_i);
    y_o    = ACC_W'(sum_n >>> eff_l2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      if (fire_o) begin
        sum_q <= '0;
        cnt_q <= '0;
      end else begin
        sum_q <= sum_n;
        cnt_q <= cnt_q + MAX_L2'(1);
      end
    end
  end
endmodule

// File: rtl/lcf_out.sv
module lcf_out #(
  parameter int ACC_W  = 22,
  parameter int DUTY_W = 9,
  parameter int DITH_W = 6,
  parameter int SH_W   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    emit_i,
  input  logic signed [ACC_W-1:0] x_i,
  input  logic [SH_W-1:0]         sh_i,
  input  logic                    dith_en_i,
  output logic [DUTY_W-1:0]       duty_o,
  output logic                    valid_o
);
  localparam int VW = ACC_W + 2;
  localparam int LW = 8;
  localparam logic signed [VW-1:0] DMAX = VW'((1 << DUTY_W) - 1);

  logic [LW-1:0]         lfsr_q;
  logic                  fb;
  logic [SH_W-1:0]       eff_sh;
  logic signed [VW-1:0]  add_v, q;
  logic [DUTY_W-1:0]     duty_n;

  always_comb begin
    fb     = lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3];
    eff_sh = (sh_i < SH_W'(DITH_W)) ? SH_W'(DITH_W) : sh_i;
    add_v  = dith_en_i ? (VW'(lfsr_q[DITH_W-1:0]) << (eff_sh - SH_W'(DITH_W))) : '0;
    q      = (VW'(x_i) + add_v) >>> eff_sh;
    if (q[VW-1])       duty_n = '0;
    else if (q > DMAX) duty_n = DMAX[DUTY_W-1:0];
    else               duty_n = q[DUTY_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lfsr_q  <= LW'(1);
      duty_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= emit_i;
      if (emit_i) begin
        duty_o <= duty_n;
        if (dith_en_i) lfsr_q <= {lfsr_q[LW-2:0], fb};
      end
    end
  end
endmodule

// File: rtl/loop_comp_filter.sv
module loop_comp_filter
  import lcf_pkg::*;
#(
  parameter int ERR_W   = 6,
  parameter int COEF_W  = 8,
  parameter int ACC_W   = 22,
  parameter int DUTY_W  = 9,
  parameter int DITH_W  = 6,
  parameter int ADDR_W  = 3,
  parameter int LSH_W   = 3,
  parameter int DEC_W   = 3,
  parameter int OSH_W   = 4,
  parameter int MAX_L2  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              coef_we_i,
  input  logic [ADDR_W-1:0] coef_addr_i,
  input  logic [COEF_W-1:0] coef_data_i,
  input  logic              sinc_sel_i,
  input  logic              dither_en_i,
  output logic              duty_valid_o,
  output logic [DUTY_W-1:0] duty_o
);
  logic signed [COEF_W-1:0] kp_s, ki_s, kd_s, kp_a, ki_a, kd_a;
  logic [LSH_W-1:0]         lsh_s, lsh_a;
  logic [DEC_W-1:0]         dec_s, dec_a;
  logic [OSH_W-1:0]         osh_s, osh_a;
  logic                     smp_q, dith_q;
  stage_e                   sel_q;
  logic signed [ERR_W-1:0]  e_q;
  logic signed [ACC_W-1:0]  pid_v, pid_acc, lpf_v, sinc_v, stage_v;
  logic                     sinc_fire, emit;

  // shadow set, written by software
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kp_s <= '0; ki_s <= '0; kd_s <= '0;
      lsh_s <= '0; dec_s <= '0; osh_s <= '0;
    end else if (coef_we_i) begin
      case (int'(coef_addr_i))
        REG_KP:  kp_s  <= coef_data_i;
        REG_KI:  ki_s  <= coef_data_i;
        REG_KD:  kd_s  <= coef_data_i;
        REG_LSH: lsh_s <= coef_data_i[LSH_W-1:0];
        REG_DEC: dec_s <= coef_data_i[DEC_W-1:0];
        REG_OSH: osh_s <= coef_data_i[OSH_W-1:0];
        default: ;
      endcase
    end
  end

  // working set and sample, copied only at a sample boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= 1'b0; e_q <= '0; sel_q <= STG_LPF; dith_q <= 1'b0;
      kp_a <= '0; ki_a <= '0; kd_a <= '0;
      lsh_a <= '0; dec_a <= '0; osh_a <= '0;
    end else begin
      smp_q <= err_valid_i;
      if (err_valid_i) begin
        e_q    <= err_i;
        sel_q  <= stage_e'(sinc_sel_i);
        dith_q <= dither_en_i;
        kp_a   <= kp_s; ki_a <= ki_s; kd_a <= kd_s;
        lsh_a  <= lsh_s; dec_a <= dec_s; osh_a <= osh_s;
      end
    end
  end

  lcf_pid #(.ERR_W(ERR_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_pid (
    .clk_i, .rst_ni, .en_i(smp_q), .e_i(e_q),
    .kp_i(kp_a), .ki_i(ki_a), .kd_i(kd_a), .pid_o(pid_v), .acc_o(pid_acc)
  );

  lcf_lpf #(.ACC_W(ACC_W), .SH_W(LSH_W)) u_lpf (
    .clk_i, .rst_ni, .en_i(smp_q), .x_i(pid_v), .sh_i(lsh_a), .y_o(lpf_v)
  );

  lcf_sinc #(.ACC_W(ACC_W), .L2_W(DEC_W), .MAX_L2(MAX_L2)) u_sinc (
    .clk_i, .rst_ni, .en_i(smp_q), .x_i(pid_v), .l2_i(dec_a),
    .y_o(sinc_v), .fire_o(sinc_fire)
  );

  always_comb begin
    stage_v = (sel_q == STG_SINC) ? sinc_v : lpf_v;
    emit    = smp_q && ((sel_q == STG_LPF) || sinc_fire);
  end

  lcf_out #(.ACC_W(ACC_W), .DUTY_W(DUTY_W), .DITH_W(DITH_W), .SH_W(OSH_W)) u_out (
    .clk_i, .rst_ni, .emit_i(emit), .x_i(stage_v), .sh_i(osh_a),
    .dith_en_i(dith_q), .duty_o(duty_o), .valid_o(duty_valid_o)
  );
endmodule

// File: rtl/lcf_chk.sv
module lcf_chk #(
  parameter int ACC_W  = 22,
  parameter int ERR_W  = 6,
  parameter int COEF_W = 8,
  parameter int DUTY_W = 9
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    err_valid_i,
  input logic                    sinc_sel_i,
  input logic                    duty_valid_o,
  input logic [DUTY_W-1:0]       duty_o,
  input logic signed [ACC_W-1:0] pid_acc_i
);
  localparam logic signed [ACC_W:0] STEP_LIM = (ACC_W+1)'((1 << (ERR_W-1)) * (1 << (COEF_W-1)));

  logic [1:0]              age_q;
  logic signed [ACC_W-1:0] acc_prev_q;
  logic signed [ACC_W:0]   acc_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q      <= '0;
      acc_prev_q <= '0;
    end else begin
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
      acc_prev_q <= pid_acc_i;
    end
  end

  assign acc_step = (ACC_W+1)'(pid_acc_i) - (ACC_W+1)'(acc_prev_q);

  // R3
  lpf_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && $past(err_valid_i, 2) && !$past(sinc_sel_i, 2)) |-> duty_valid_o);

  // R8
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_valid_o |-> (age_q >= 2'd2 && $past(err_valid_i, 2)));

  // R8
  duty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && !duty_valid_o) |-> $stable(duty_o));

  // R2
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_step <= STEP_LIM) && (acc_step >= -STEP_LIM));
endmodule

bind loop_comp_filter lcf_chk #(
  .ACC_W(ACC_W), .ERR_W(ERR_W), .COEF_W(COEF_W), .DUTY_W(DUTY_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .err_valid_i(err_valid_i),
  .sinc_sel_i(sinc_sel_i), .duty_valid_o(duty_valid_o),
  .duty_o(duty_o), .pid_acc_i(pid_acc)
);

// File: tb/sim_loop_comp_filter.sv
module sim_loop_comp_filter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       err_valid_i = 1'b0;
  logic [5:0] err_i = '0;
  logic       coef_we_i = 1'b0;
  logic [2:0] coef_addr_i = '0;
  logic [7:0] coef_data_i = '0;
  logic       sinc_sel_i = 1'b0;
  logic       dither_en_i = 1'b0;
  logic       duty_valid_o;
  logic [8:0] duty_o;

  always #4 clk_i = ~clk_i;

  loop_comp_filter u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  longint s_kp, s_ki, s_kd, s_k, s_d, s_s;
  longint a_kp, a_ki, a_kd, a_k, a_d, a_s;
  longint m_acc, m_eprev, m_s1, m_s2, m_sum, m_cnt, m_lfsr, m_last;

  localparam longint HI = 2097151;
  localparam longint LO = -2097152;

  function automatic longint sat(longint v);
    if (v > HI) return HI;
    if (v < LO) return LO;
    return v;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic shadow_wr(int a, int v);
    longint sv = (v >= 128) ? v - 256 : v;
    case (a)
      0: s_kp = sv;
      1: s_ki = sv;
      2: s_kd = sv;
      3: s_k  = v & 7;
      4: s_d  = v & 7;
      5: s_s  = v & 15;
      default: ;
    endcase
  endtask

  task automatic model_step(longint e, bit sel, bit dith, output bit emit, output longint duty);
    longint accn, pid, sumn, sincy, x, d, sh, add, q, fb;
    bit fire;
    accn    = sat(m_acc + a_ki * e);
    pid     = sat(accn + a_kp * e + a_kd * (e - m_eprev));
    m_acc   = accn;
    m_eprev = e;
    m_s1    = m_s1 + ((pid - m_s1) >>> a_k);
    m_s2    = m_s2 + ((m_s1 - m_s2) >>> a_k);
    d       = (a_d > 4) ? 4 : a_d;
    sumn    = m_sum + pid;
    fire    = (m_cnt >= ((64'sd1 << d) - 1));
    sincy   = sumn >>> d;
    if (fire) begin m_sum = 0; m_cnt = 0; end
    else begin m_sum = sumn; m_cnt++; end
    x    = sel ? sincy : m_s2;
    emit = sel ? fire : 1'b1;
    duty = m_last;
    if (emit) begin
      sh  = (a_s < 6) ? 6 : a_s;
      add = dith ? ((m_lfsr & 63) << (sh - 6)) : 0;
      q   = (x + add) >>> sh;
      duty = (q < 0) ? 0 : (q > 511) ? 511 : q;
      if (dith) begin
        fb = ((m_lfsr >> 7) ^ (m_lfsr >> 5) ^ (m_lfsr >> 4) ^ (m_lfsr >> 3)) & 1;
        m_lfsr = ((m_lfsr << 1) | fb) & 255;
      end
    end
  endtask

  task automatic write_coef(int a, int v);
    @(negedge clk_i);
    coef_we_i = 1'b1; coef_addr_i = 3'(a); coef_data_i = 8'(v);
    shadow_wr(a, v);
    @(negedge clk_i);
    coef_we_i = 1'b0;
  endtask

  task automatic send(int e, bit sel, bit dith, bit wr, int wa, int wv, string tag);
    bit emit;
    longint exp;
    @(negedge clk_i);
    err_valid_i = 1'b1; err_i = 6'(e); sinc_sel_i = sel; dither_en_i = dith;
    a_kp = s_kp; a_ki = s_ki; a_kd = s_kd; a_k = s_k; a_d = s_d; a_s = s_s;
    if (wr) begin
      coef_we_i = 1'b1; coef_addr_i = 3'(wa); coef_data_i = 8'(wv);
      shadow_wr(wa, wv);
    end
    model_step(e, sel, dith, emit, exp);
    @(negedge clk_i);
    err_valid_i = 1'b0; coef_we_i = 1'b0;
    @(negedge clk_i);
    check(tag, duty_valid_o, emit);
    check(tag, duty_o, exp);
    m_last = exp;
  endtask

  task automatic set_all(int kp, int ki, int kd, int k, int d, int s);
    write_coef(0, kp); write_coef(1, ki); write_coef(2, kd);
    write_coef(3, k);  write_coef(4, d);  write_coef(5, s);
  endtask

  initial begin
    int r;
    r = $urandom(32'h5eed);
    s_kp = 0; s_ki = 0; s_kd = 0; s_k = 0; s_d = 0; s_s = 0;
    m_acc = 0; m_eprev = 0; m_s1 = 0; m_s2 = 0; m_sum = 0; m_cnt = 0;
    m_lfsr = 1; m_last = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 reset state
    check("R9", duty_valid_o, 0);
    check("R9", duty_o, 0);
    send(10, 0, 0, 0, 0, 0, "R9");

    // R1 PID terms
    set_all(40, 3, -20, 0, 0, 6);
    foreach (r1_pat[i]) send(r1_pat[i], 0, 0, 0, 0, 0, "R1");

    // R3 two-pole settling
    set_all(0, 0, 0, 2, 0, 6);
    write_coef(0, 100);
    for (int i = 0; i < 12; i++) send(30, 0, 0, 0, 0, 0, "R3");
    write_coef(3, 5);
    for (int i = 0; i < 12; i++) send(-20, 0, 0, 0, 0, 0, "R3");

    // R2 saturation both ways
    set_all(0, 127, 0, 0, 0, 12);
    for (int i = 0; i < 600; i++) send(31, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) send(-32, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 620; i++) send(-32, 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) send(31, 0, 0, 0, 0, 0, "R2");

    // R4 SINC decimation
    set_all(60, 2, 10, 1, 2, 6);
    for (int i = 0; i < 12; i++) send(i * 5 - 20, 1, 0, 0, 0, 0, "R4");
    write_coef(4, 7);
    for (int i = 0; i < 20; i++) send(25 - i, 1, 0, 0, 0, 0, "R4");
    for (int i = 0; i < 3; i++) send(9, 1, 0, 0, 0, 0, "R4");
    write_coef(4, 1);
    for (int i = 0; i < 4; i++) send(-9, 1, 0, 0, 0, 0, "R4");
    for (int i = 0; i < 4; i++) send(12, 0, 0, 0, 0, 0, "R4");

    // R5 scaling
    set_all(127, 0, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) send(31 - i * 12, 0, 0, 0, 0, 0, "R5");
    write_coef(5, 15); write_coef(1, 100);
    for (int i = 0; i < 8; i++) send(31, 0, 0, 0, 0, 0, "R5");

    // R6 dither
    set_all(50, 0, 0, 0, 0, 6);
    for (int i = 0; i < 20; i++) send(7, 0, 1, 0, 0, 0, "R6");
    write_coef(5, 10);
    for (int i = 0; i < 20; i++) send(-3 + i, 0, 1, 0, 0, 0, "R6");
    for (int i = 0; i < 5; i++) send(7, 0, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 5; i++) send(7, 0, 1, 0, 0, 0, "R6");

    // R7 coefficient boundary and unused addresses
    set_all(10, 0, 0, 0, 0, 6);
    send(20, 0, 0, 1, 0, 120, "R7");
    send(20, 0, 0, 0, 0, 0, "R7");
    write_coef(6, 255); write_coef(7, 200);
    for (int i = 0; i < 3; i++) send(15, 0, 0, 0, 0, 0, "R7");

    // R8 random mix with mid-run writes
    set_all(20, 1, 5, 2, 2, 7);
    for (int i = 0; i < 3000; i++) begin
      int e = int'($urandom_range(63)) - 32;
      bit sel = ($urandom_range(3) == 0);
      bit dith = $urandom_range(1);
      bit wr = ($urandom_range(9) == 0);
      send(e, sel, dith, wr, int'($urandom_range(7)), int'($urandom_range(255)), "R8");
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  int r1_pat[6] = '{5, -7, 31, -32, 0, 12};

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule